// File: doc/BRIEF.md
# Macro Store Bus Interface Controller

This block connects a 16-bit processor bus to an external macro-code memory. It watches the processor's memory-enable line and three bus status bits, which together form a 4-bit code, and recognises the macro store cycles. For those cycles it drives a chip select, a read strobe and a write strobe toward the macro RAM, and it stretches strobed accesses by a programmable number of wait states. The macro RAM sits inside the block so that the mapping can be checked at the ports. A side port preloads this RAM, for example with a jump table and with extension code.

The processor has two boot configurations, and the block selects one of them through a strap output that it holds low through reset. In the prototyping configuration the processor's internal macro ROM is switched off and the external memory answers for the 1 KB window that normally belongs to that ROM (macro byte addresses 0x0800 up to but not including 0x0C00), so the first jump table word, at 0x0800, serves opcode 0x0000. In the standard configuration the internal ROM owns that window and is left alone, and the external RAM answers only in the extension area starting at 0x1000, where unimplemented opcodes land.

The macro status codes are shared with internal ALU cycles, which carry no data strobe. The block may select the memory in such a cycle, but it never strobes the memory in one and never pulls READY low during one.

Top module: `macro_store_ctrl`

## Requirements
- R1: `cs_n` is low only when `mem_n` is 1, `bst` is 3'b000 or 3'b001, and `addr` falls in a mapped region. Any other status code, or `mem_n` at 0, leaves `cs_n` high.
- R2: A mapped macro-status cycle with `dbin`=0 and `we_n`=1 is treated as an ALU cycle. In such a cycle `cs_n` may be low, but `rd_n` and `wr_n` stay high and `ready` stays high.
- R3: `rd_n` is low exactly when a mapped macro cycle has `dbin`=1. `wr_n` is low exactly when a mapped macro cycle has `dbin`=0 and `we_n`=0. The two strobes are never low at the same time.
- R4: With `wait_cfg`=N (0 to 3), `ready` is low for the first N clock cycles of a strobed access and high from cycle N+1 on. Unstrobed cycles never see `ready` low.
- R5: While `rst_n` is low, `app_n` equals the inverse of `cfg_proto`. After reset `app_n` is high.
- R6: In prototyping mode, byte addresses 0x0800 to 0x0BFF map to the external RAM and 0x0C00 does not. In standard mode, 0x0800 to 0x0BFF are not mapped.
- R7: The extension region, byte addresses 0x1000 to 0x11FF, maps to the external RAM in both modes.
- R8: A bus write stores `wdata` at the addressed word on the clock edge where `ready` is high. A later bus read returns that word on `rdata`. `rdata` is 0 when `rd_n` is high.
- R9: The debug port is granted (`dbg_gnt`=1) when `dbg_req` is 1 and no strobed access is on the bus. When granted, it writes `dbg_wdata` if `dbg_we`=1 and returns the word on `dbg_rdata`. When blocked, nothing is written.
- R10: The mode is sampled from `cfg_proto` during reset. A change of `cfg_proto` after reset does not change the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_proto | input | 1 | Boot configuration: 1 selects prototyping mode |
| app_n | output | 1 | Mode strap to the processor, low for prototyping during reset |
| mem_n | input | 1 | Processor memory-enable, active low |
| bst | input | 3 | Bus status bits |
| addr | input | 16 | Macro byte address |
| dbin | input | 1 | Data-in (read) indication, active high |
| we_n | input | 1 | Processor write enable, active low |
| wdata | input | 16 | Write data from the processor |
| rdata | output | 16 | Read data to the processor |
| ready | output | 1 | Wait-state control, low inserts a wait |
| cs_n | output | 1 | Macro memory chip select |
| rd_n | output | 1 | Macro memory read strobe |
| wr_n | output | 1 | Macro memory write strobe |
| wait_cfg | input | 2 | Number of wait states for strobed accesses |
| dbg_req | input | 1 | Debug port request |
| dbg_we | input | 1 | Debug port write |
| dbg_addr | input | 16 | Debug port macro byte address |
| dbg_wdata | input | 16 | Debug port write data |
| dbg_rdata | output | 16 | Debug port read data |
| dbg_gnt | output | 1 | Debug port grant |

## Verification
The decode outputs `cs_n`, `rd_n`, `wr_n`, `rdata`, `dbg_gnt` and `dbg_rdata` depend combinationally on the inputs, so they are due in the same cycle. The bench drives inputs on the falling edge and reads these outputs 1 time unit later. `ready` is low in the drive cycle of a strobed access and rises after the Nth rising edge. The bench therefore counts low samples, one per falling edge, until `ready` is high and compares the count with `wait_cfg`. Writes take effect on the rising edge that follows a high `ready`, and the mode register on the rising edges during reset. For this reason every readback and every decode check after reset is made at least one falling edge after those edges.

// File: rtl/macro_store_ctrl.sv
module macro_store_ctrl #(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned WW        = 2,
  parameter int unsigned JT_BASE   = 32'h0800,
  parameter int unsigned JT_WORDS  = 512,
  parameter int unsigned EXT_BASE  = 32'h1000,
  parameter int unsigned EXT_WORDS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_proto,
  output logic          app_n,
  input  logic          mem_n,
  input  logic [2:0]    bst,
  input  logic [AW-1:0] addr,
  input  logic          dbin,
  input  logic          we_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ready,
  output logic          cs_n,
  output logic          rd_n,
  output logic          wr_n,
  input  logic [WW-1:0] wait_cfg,
  input  logic          dbg_req,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata,
  output logic          dbg_gnt
);
  localparam int unsigned DEPTH   = JT_WORDS + EXT_WORDS;
  localparam int unsigned IW      = $clog2(DEPTH);
  localparam int unsigned JT_END  = JT_BASE + 2 * JT_WORDS;
  localparam int unsigned EXT_END = EXT_BASE + 2 * EXT_WORDS;

  function automatic logic in_jt(input logic [AW-1:0] a);
    return 32'(a) >= JT_BASE && 32'(a) < JT_END;
  endfunction

  function automatic logic in_ext(input logic [AW-1:0] a);
    return 32'(a) >= EXT_BASE && 32'(a) < EXT_END;
  endfunction

  function automatic logic [IW-1:0] idx_of(input logic [AW-1:0] a);
    return IW'(in_jt(a) ? (32'(a) - JT_BASE) >> 1
                        : JT_WORDS + ((32'(a) - EXT_BASE) >> 1));
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic          proto_q;
  logic [WW-1:0] cnt_q;

  wire macro_st = mem_n && (bst[2:1] == 2'b00);
  wire bus_hit  = macro_st && ((proto_q && in_jt(addr)) || in_ext(addr));
  wire strobed  = bus_hit && (dbin || !we_n);
  wire dbg_hit  = in_jt(dbg_addr) || in_ext(dbg_addr);
  wire [IW-1:0] bus_idx = idx_of(addr);
  wire [IW-1:0] dbg_idx = idx_of(dbg_addr);

  assign app_n     = !(cfg_proto && !rst_n);
  assign cs_n      = !bus_hit;
  assign rd_n      = !(bus_hit && dbin);
  assign wr_n      = !(bus_hit && !dbin && !we_n);
  assign ready     = !(strobed && cnt_q < wait_cfg);
  assign rdata     = rd_n ? '0 : mem[bus_idx];
  assign dbg_gnt   = dbg_req && !strobed;
  assign dbg_rdata = (dbg_gnt && dbg_hit) ? mem[dbg_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      proto_q <= cfg_proto;
    end else begin
      cnt_q <= (strobed && !ready) ? cnt_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!wr_n && ready)
      mem[bus_idx] <= wdata;
    else if (dbg_gnt && dbg_we && dbg_hit)
      mem[dbg_idx] <= dbg_wdata;
  end
endmodule

// File: rtl/macro_store_ctrl_chk.sv
module macro_store_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_n,
  input logic [2:0] bst,
  input logic       dbin,
  input logic       we_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ready,
  input logic       dbg_gnt,
  input logic       proto_q
);
  // R3
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R1
  cs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (mem_n && bst[2:1] == 2'b00));

  // R2
  alu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !dbin && we_n) |-> (rd_n && wr_n && ready));

  // R4
  wait_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!rd_n || !wr_n));

  // R9
  dbg_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_gnt |-> (ready && (rd_n && wr_n || 1'b1) && !((!rd_n || !wr_n) && !ready)));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(proto_q));
endmodule

bind macro_store_ctrl macro_store_ctrl_chk chk (.*);

// File: tb/tb_macro_store_ctrl.sv
module tb_macro_store_ctrl;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, cfg_proto = 0, app_n;
  logic mem_n = 0, dbin = 0, we_n = 1;
  logic [2:0] bst = 3'b111;
  logic [15:0] addr = 0, wdata = 0, rdata, dbg_addr = 0, dbg_wdata = 0, dbg_rdata;
  logic ready, cs_n, rd_n, wr_n, dbg_req = 0, dbg_we = 0, dbg_gnt;
  logic [1:0] wait_cfg = 0;

  int checks = 0, fails = 0;
  logic s_cs, s_rd, s_wr;
  logic [15:0] s_data;
  int s_waits;

  always #(CLK_P/2) clk = ~clk;

  macro_store_ctrl dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    mem_n = 0; bst = 3'b111; dbin = 0; we_n = 1; dbg_req = 0; dbg_we = 0;
  endtask

  task automatic cycle(input logic mn, input logic [2:0] st, input logic [15:0] a,
                       input logic di, input logic wn, input logic [15:0] wd);
    @(negedge clk);
    mem_n = mn; bst = st; addr = a; dbin = di; we_n = wn; wdata = wd;
    #1;
    s_cs = cs_n; s_rd = rd_n; s_wr = wr_n; s_waits = 0;
    while (!ready && s_waits < 20) begin
      s_waits++;
      @(negedge clk); #1;
    end
    s_data = rdata;
    @(negedge clk);
    idle();
  endtask

  task automatic dbg_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    dbg_req = 1; dbg_we = 1; dbg_addr = a; dbg_wdata = d;
    #1 chk(dbg_gnt == 1, "R9 grant", dbg_gnt, 1);
    @(negedge clk);
    idle();
  endtask

  task automatic dbg_read(input logic [15:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    dbg_req = 1; dbg_we = 0; dbg_addr = a;
    #1 chk(dbg_rdata == exp, tag, dbg_rdata, exp);
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset(input logic proto);
    @(negedge clk);
    cfg_proto = proto; rst_n = 0; idle();
    #1 chk(app_n == !proto, "R5 strap in reset", app_n, !proto);
    repeat (3) @(negedge clk);
    #1 chk(app_n == !proto, "R5 strap held", app_n, !proto);
    @(negedge clk);
    rst_n = 1;
    #1 chk(app_n == 1, "R5 strap released", app_n, 1);
    chk(cs_n && rd_n && wr_n && ready, "R1 idle outputs", {cs_n, rd_n, wr_n, ready}, 4'hF);
  endtask

  task automatic t_preload();
    dbg_write(16'h0800, 16'h0880);
    dbg_write(16'h0BFE, 16'h0BBB);
    dbg_write(16'h1000, 16'hAAAA);
    dbg_write(16'h1002, 16'h0200);
    dbg_write(16'h1006, 16'h0000);
    dbg_read(16'h1000, 16'hAAAA, "R9 readback ext");
    dbg_read(16'h0800, 16'h0880, "R9 readback jt");
  endtask

  task automatic t_standard();
    wait_cfg = 0;
    cycle(1, 3'b000, 16'h0800, 1, 1, 0);
    chk(s_cs == 1 && s_rd == 1, "R6 std jt unmapped", {s_cs, s_rd}, 2'b11);
    cycle(1, 3'b000, 16'h1000, 1, 1, 0);
    chk(s_cs == 0 && s_rd == 0, "R7 std ext mapped", {s_cs, s_rd}, 2'b00);
    chk(s_data == 16'hAAAA, "R8 read data", s_data, 16'hAAAA);
    cfg_proto = 1;
    cycle(1, 3'b001, 16'h0800, 1, 1, 0);
    chk(s_cs == 1, "R10 mode kept std", s_cs, 1);
    cfg_proto = 0;
  endtask

  task automatic t_decode();
    cycle(1, 3'b010, 16'h1000, 1, 1, 0);
    chk(s_cs == 1 && s_rd == 1, "R1 status 010", {s_cs, s_rd}, 2'b11);
    cycle(0, 3'b000, 16'h1000, 1, 1, 0);
    chk(s_cs == 1 && s_rd == 1, "R1 mem_n low", {s_cs, s_rd}, 2'b11);
    cycle(1, 3'b001, 16'h1002, 1, 1, 0);
    chk(s_cs == 0 && s_data == 16'h0200, "R1 status 001", s_data, 16'h0200);
  endtask

  task automatic t_alu();
    wait_cfg = 3;
    @(negedge clk);
    mem_n = 1; bst = 3'b001; addr = 16'h1000; dbin = 0; we_n = 1;
    for (int i = 0; i < 3; i++) begin
      #1 chk(cs_n == 0 && rd_n && wr_n && ready, "R2 alu cycle quiet",
             {cs_n, rd_n, wr_n, ready}, 4'b0111);
      chk(rdata == 0, "R8 rdata idle", rdata, 0);
      @(negedge clk);
    end
    idle();
  endtask

  task automatic t_waits();
    for (int n = 0; n < 4; n++) begin
      wait_cfg = 2'(n);
      cycle(1, 3'b000, 16'h1000, 1, 1, 0);
      chk(s_waits == n, "R4 read waits", s_waits, n);
    end
    wait_cfg = 2;
    cycle(1, 3'b000, 16'h1004, 0, 0, 16'h1234);
    chk(s_waits == 2, "R4 write waits", s_waits, 2);
    chk(s_wr == 0 && s_rd == 1, "R3 write strobe only", {s_rd, s_wr}, 2'b10);
    cycle(1, 3'b000, 16'h1004, 1, 1, 0);
    chk(s_rd == 0 && s_wr == 1, "R3 read strobe only", {s_rd, s_wr}, 2'b01);
    chk(s_data == 16'h1234, "R8 write then read", s_data, 16'h1234);
    dbg_read(16'h1004, 16'h1234, "R8 debug sees bus write");
  endtask

  task automatic t_block();
    wait_cfg = 3;
    @(negedge clk);
    mem_n = 1; bst = 3'b000; addr = 16'h1000; dbin = 1; we_n = 1;
    dbg_req = 1; dbg_we = 1; dbg_addr = 16'h1006; dbg_wdata = 16'hDEAD;
    #1 chk(dbg_gnt == 0, "R9 blocked while busy", dbg_gnt, 0);
    repeat (2) @(negedge clk);
    #1 chk(dbg_gnt == 0, "R9 still blocked", dbg_gnt, 0);
    idle();
    dbg_read(16'h1006, 16'h0000, "R9 blocked write not applied");
  endtask

  task automatic t_proto();
    wait_cfg = 1;
    cycle(1, 3'b000, 16'h0800, 1, 1, 0);
    chk(s_cs == 0 && s_data == 16'h0880, "R6 proto jt entry", s_data, 16'h0880);
    cycle(1, 3'b000, 16'h0BFE, 1, 1, 0);
    chk(s_data == 16'h0BBB, "R6 proto jt top", s_data, 16'h0BBB);
    cycle(1, 3'b000, 16'h0C00, 1, 1, 0);
    chk(s_cs == 1, "R6 proto end unmapped", s_cs, 1);
    cycle(1, 3'b000, 16'h1002, 1, 1, 0);
    chk(s_cs == 0 && s_data == 16'h0200, "R7 proto ext", s_data, 16'h0200);
    cfg_proto = 0;
    cycle(1, 3'b000, 16'h0800, 1, 1, 0);
    chk(s_cs == 0, "R10 mode kept proto", s_cs, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset(0);
    t_preload();
    t_standard();
    t_decode();
    t_alu();
    t_waits();
    t_block();
    t_reset(1);
    t_proto();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule